// File: doc/BRIEF.md
# I2C Master Register and FIFO Front End

This block sits between a 32-bit memory-mapped register port and the byte engine of a small I2C master. Software drives a transfer by writing command words. Each word holds one byte plus flags that ask for a START before the byte and a STOP after it. The words are queued in a command FIFO, and the engine takes them one at a time. Bytes that the engine reads from the bus go the other way, through a receive FIFO that software empties by reading a data register.

The block also holds the control settings: core enable, fast-speed select and two FIFO thresholds. It holds the three timing counts (SCL low, SCL high, SDA hold) and passes them to the engine. It keeps an interrupt status register with a matching enable mask, and drives one interrupt line. The two "ready" conditions are compared against programmable FIFO thresholds. Error events from the engine are held as sticky flags until software clears them.

Top module: `i2cf_front`

## Requirements
- R1: After synchronous reset: control reads 0, the interrupt enable reads 0, both FIFO levels read 0, the status register reads 0, `cmd_valid`, `core_en` and `irq` are 0, and the interrupt status reads 0x1 (only the live TX-ready bit is set).
- R2: Registers are decoded by byte address bits [5:2]. The map is: 0x00 command (write), 0x04 receive data (read), 0x08 control, 0x0C interrupt enable, 0x10 interrupt status, 0x14 status, 0x18 command level, 0x1C receive level, 0x20 SCL low count, 0x24 SCL high count, 0x28 SDA hold count. The three counts and control read back the value written, truncated to their widths (counts 16 bits, control 6 bits), and the counts appear on the matching output ports.
- R3: While enabled, a write to 0x00 queues bits [9:0]: bit 9 is START, bit 8 is STOP and bits [7:0] are the byte. Queued words are presented on `cmd_word` with `cmd_valid` in write order. A word is removed on a cycle with `cmd_valid` and `cmd_ready` both high, and 0x18 reads the number of queued words.
- R4: A write to 0x00 while the command FIFO holds DEPTH (4) words is ignored. The level stays 4 and the queued words are unchanged.
- R5: While enabled, each `rx_valid` cycle queues `rx_byte`. A read of 0x04 returns the oldest byte in bits [7:0] and removes it, and 0x1C reads the receive level.
- R6: A read of 0x04 while the receive FIFO is empty returns 0 and leaves the level at 0.
- R7: A byte delivered while the receive FIFO is full is dropped, and interrupt status bit 4 (receive overflow) is set.
- R8: Interrupt status bit 0 (TX ready) reads 1 exactly while the command level is at or below control bits [3:2]. Bit 1 (RX ready) reads 1 exactly while the receive level is above control bits [5:4]. Both bits are live, and writing 1 to them has no effect.
- R9: Interrupt status bit 2 (NACK) and bit 3 (arbitration lost) are set by one-cycle `ev_nack` and `ev_arb` pulses while enabled. Bits 2 to 4 stay set until a 1 is written to that bit at 0x10. If a set and a clear arrive in the same cycle, the set wins.
- R10: `irq` is high exactly when some interrupt status bit and the same bit of the enable register (0x0C, bits [4:0]) are both 1.
- R11: Status bit 0 at 0x14 reads 1 while the core is enabled and either `eng_busy` is high or the command FIFO is not empty; otherwise it reads 0.
- R12: While control bit 0 is 0, both FIFOs are held empty, command writes, received bytes and engine events are ignored, and `core_en` is 0. After the bit is set again the core starts with both FIFOs empty.
- R13: `core_en` follows control bit 0 and `fast_mode` follows control bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops receive data at 0x04) |
| reg_addr | input | 6 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from address |
| cmd_valid | output | 1 | A command word is available |
| cmd_word | output | 10 | Oldest command word {START, STOP, byte} |
| cmd_ready | input | 1 | Engine accepts the presented command word |
| rx_valid | input | 1 | Engine delivers a received byte |
| rx_byte | input | 8 | Received byte |
| ev_nack | input | 1 | One-cycle NACK-detected event |
| ev_arb | input | 1 | One-cycle arbitration-lost event |
| eng_busy | input | 1 | Engine is on the bus |
| core_en | output | 1 | Core enable to the engine |
| fast_mode | output | 1 | Fast bus speed select |
| scl_lo_cnt | output | 16 | SCL low count |
| scl_hi_cnt | output | 16 | SCL high count |
| sda_hold_cnt | output | 16 | SDA hold count |
| irq | output | 1 | Interrupt request |

## Verification
Every threshold value from 0 to 3 is tried against every level of both FIFOs from empty to full. This shows whether the TX-ready test uses "at or below" and the RX-ready test uses "strictly above", and whether each threshold is taken from the correct control field. The receive sweep goes one byte past full, which separates a dropped byte from an overwritten one and checks that read order stays oldest-first. The command words mix START-only, STOP-only, both-flag and no-flag patterns, so a swapped flag or a reordered entry shows up. Event pulses arrive with their mask bit either off or on, and one arrives in the same cycle as its own clear, which shows whether set or clear takes priority.

// File: rtl/i2cf_pkg.sv
package i2cf_pkg;

    localparam int ADDR_W = 6;
    localparam int DATA_W = 32;
    localparam int CMD_W  = 10;
    localparam int BYTE_W = 8;
    localparam int IRQ_N  = 5;
    localparam int CTRL_W = 6;

    // word index = byte address [5:2]
    typedef enum logic [3:0] {
        RG_CMD  = 4'd0,
        RG_RXD  = 4'd1,
        RG_CTRL = 4'd2,
        RG_IEN  = 4'd3,
        RG_IST  = 4'd4,
        RG_STAT = 4'd5,
        RG_CLVL = 4'd6,
        RG_RLVL = 4'd7,
        RG_SLO  = 4'd8,
        RG_SHI  = 4'd9,
        RG_HOLD = 4'd10
    } reg_sel_e;

    // field order matches control register bit positions (bit 0 = en)
    typedef struct packed {
        logic [1:0] rx_thr;
        logic [1:0] tx_thr;
        logic       fast;
        logic       en;
    } ctrl_t;

    // bit 4 down to bit 0 of status / enable
    typedef struct packed {
        logic rx_ovf;
        logic arb;
        logic nack;
        logic rx_rdy;
        logic tx_rdy;
    } irq_vec_t;

    function automatic logic reg_hit(input logic [ADDR_W-1:0] a, input reg_sel_e r);
        return a[ADDR_W-1:2] == r;
    endfunction

endpackage

// File: rtl/i2cf_fifo.sv
module i2cf_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [W-1:0]     wdata,
    input  logic             pop,
    output logic [W-1:0]     rdata,
    output logic [LVL_W-1:0] level,
    output logic             full,
    output logic             empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wp_q, rp_q;
    logic             do_push, do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    assign full    = (level == LVL_W'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rp_q];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp_q  <= '0;
            rp_q  <= '0;
            level <= '0;
        end else begin
            if (do_push) wp_q <= bump(wp_q);
            if (do_pop)  rp_q <= bump(rp_q);
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !flush && !rst) mem[wp_q] <= wdata;
    end

endmodule

// File: rtl/i2cf_irq.sv
module i2cf_irq
    import i2cf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ien_we,
    input  logic             ist_we,
    input  logic [IRQ_N-1:0] wdata,
    input  logic             tx_rdy,
    input  logic             rx_rdy,
    input  logic             set_nack,
    input  logic             set_arb,
    input  logic             set_ovf,
    output logic [IRQ_N-1:0] ien,
    output logic [IRQ_N-1:0] ist,
    output logic             irq
);
    irq_vec_t   stat;
    logic [2:0] stk_q;      // {ovf, arb, nack}
    logic [2:0] clr, setv;

    assign clr  = ist_we ? wdata[4:2] : 3'b000;
    assign setv = {set_ovf, set_arb, set_nack};

    always_ff @(posedge clk) begin
        if (rst) begin
            stk_q <= '0;
            ien   <= '0;
        end else begin
            stk_q <= (stk_q & ~clr) | setv;
            if (ien_we) ien <= wdata;
        end
    end

    always_comb begin
        stat.rx_ovf = stk_q[2];
        stat.arb    = stk_q[1];
        stat.nack   = stk_q[0];
        stat.rx_rdy = rx_rdy;
        stat.tx_rdy = tx_rdy;
    end

    assign ist = stat;
    assign irq = |(ist & ien);

endmodule

// File: rtl/i2cf_front.sv
module i2cf_front
    import i2cf_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [5:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              cmd_valid,
    output logic [9:0]        cmd_word,
    input  logic              cmd_ready,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              ev_nack,
    input  logic              ev_arb,
    input  logic              eng_busy,
    output logic              core_en,
    output logic              fast_mode,
    output logic [CNT_W-1:0]  scl_lo_cnt,
    output logic [CNT_W-1:0]  scl_hi_cnt,
    output logic [CNT_W-1:0]  sda_hold_cnt
    ,output logic             irq
);
    localparam int LVL_W = $clog2(DEPTH + 1);

    ctrl_t            ctrl_q;
    logic [LVL_W-1:0] cmd_lvl, rx_lvl;
    logic             cmd_full, cmd_empty, rx_full, rx_empty;
    logic [BYTE_W-1:0] rx_head;
    logic [IRQ_N-1:0] ien, ist;
    logic             wr_cmd, rd_pop, rx_push, busy;
    logic             tx_rdy, rx_rdy;

    // ---------------- register writes ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q       <= '0;
            scl_lo_cnt   <= '0;
            scl_hi_cnt   <= '0;
            sda_hold_cnt <= '0;
        end else if (reg_wr) begin
            if (reg_hit(reg_addr, RG_CTRL)) ctrl_q       <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
            if (reg_hit(reg_addr, RG_SLO))  scl_lo_cnt   <= reg_wdata[CNT_W-1:0];
            if (reg_hit(reg_addr, RG_SHI))  scl_hi_cnt   <= reg_wdata[CNT_W-1:0];
            if (reg_hit(reg_addr, RG_HOLD)) sda_hold_cnt <= reg_wdata[CNT_W-1:0];
        end
    end

    assign core_en   = ctrl_q.en;
    assign fast_mode = ctrl_q.fast;

    assign wr_cmd  = reg_wr && reg_hit(reg_addr, RG_CMD) && ctrl_q.en;
    assign rd_pop  = reg_rd && reg_hit(reg_addr, RG_RXD);
    assign rx_push = rx_valid && ctrl_q.en;

    // ---------------- FIFOs ----------------
    i2cf_fifo #(.W(CMD_W), .DEPTH(DEPTH), .LVL_W(LVL_W)) cmd_fifo_i (
        .clk   (clk),
        .rst   (rst),
        .flush (!ctrl_q.en),
        .push  (wr_cmd),
        .wdata (reg_wdata[CMD_W-1:0]),
        .pop   (cmd_ready),
        .rdata (cmd_word),
        .level (cmd_lvl),
        .full  (cmd_full),
        .empty (cmd_empty)
    );

    i2cf_fifo #(.W(BYTE_W), .DEPTH(DEPTH), .LVL_W(LVL_W)) rx_fifo_i (
        .clk   (clk),
        .rst   (rst),
        .flush (!ctrl_q.en),
        .push  (rx_push),
        .wdata (rx_byte),
        .pop   (rd_pop),
        .rdata (rx_head),
        .level (rx_lvl),
        .full  (rx_full),
        .empty (rx_empty)
    );

    assign cmd_valid = !cmd_empty;

    // ---------------- interrupts ----------------
    assign tx_rdy = cmd_lvl <= LVL_W'(ctrl_q.tx_thr);
    assign rx_rdy = rx_lvl  >  LVL_W'(ctrl_q.rx_thr);

    i2cf_irq irq_i (
        .clk      (clk),
        .rst      (rst),
        .ien_we   (reg_wr && reg_hit(reg_addr, RG_IEN)),
        .ist_we   (reg_wr && reg_hit(reg_addr, RG_IST)),
        .wdata    (reg_wdata[IRQ_N-1:0]),
        .tx_rdy   (tx_rdy),
        .rx_rdy   (rx_rdy),
        .set_nack (ev_nack && ctrl_q.en),
        .set_arb  (ev_arb && ctrl_q.en),
        .set_ovf  (rx_push && rx_full),
        .ien      (ien),
        .ist      (ist),
        .irq      (irq)
    );

    assign busy = ctrl_q.en && (eng_busy || cmd_full || !cmd_empty);

    // ---------------- read mux ----------------
    always_comb begin
        reg_rdata = '0;
        case (reg_addr[5:2])
            RG_RXD:  reg_rdata[BYTE_W-1:0] = rx_empty ? '0 : rx_head;
            RG_CTRL: reg_rdata[CTRL_W-1:0] = ctrl_q;
            RG_IEN:  reg_rdata[IRQ_N-1:0]  = ien;
            RG_IST:  reg_rdata[IRQ_N-1:0]  = ist;
            RG_STAT: reg_rdata[0]          = busy;
            RG_CLVL: reg_rdata[LVL_W-1:0]  = cmd_lvl;
            RG_RLVL: reg_rdata[LVL_W-1:0]  = rx_lvl;
            RG_SLO:  reg_rdata[CNT_W-1:0]  = scl_lo_cnt;
            RG_SHI:  reg_rdata[CNT_W-1:0]  = scl_hi_cnt;
            RG_HOLD: reg_rdata[CNT_W-1:0]  = sda_hold_cnt;
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/i2cf_front_chk.sv
module i2cf_front_chk
    import i2cf_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int LVL_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             reg_wr,
    input logic             reg_rd,
    input logic [5:0]       reg_addr,
    input logic [31:0]      reg_wdata,
    input logic [31:0]      reg_rdata,
    input logic             rx_valid,
    input logic             core_en,
    input logic [LVL_W-1:0] cmd_lvl,
    input logic [LVL_W-1:0] rx_lvl,
    input logic [IRQ_N-1:0] ist,
    input logic [IRQ_N-1:0] ien,
    input logic             irq
);
    localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);

    assert_full_write_ignored_R4: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr[5:2] == RG_CMD && cmd_lvl == FULL) |=> (cmd_lvl <= $past(cmd_lvl)));

    assert_empty_read_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr[5:2] == RG_RXD && rx_lvl == '0) |-> (reg_rdata == 32'd0));

    assert_overflow_flag_R7: assert property (@(posedge clk) disable iff (rst)
        (core_en && rx_valid && rx_lvl == FULL) |=> (ist[4] && rx_lvl <= FULL));

    assert_nack_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (ist[2] && !(reg_wr && reg_addr[5:2] == RG_IST && reg_wdata[2])) |=> ist[2]);

    assert_arb_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (ist[3] && !(reg_wr && reg_addr[5:2] == RG_IST && reg_wdata[3])) |=> ist[3]);

    assert_irq_masked_R10: assert property (@(posedge clk) disable iff (rst)
        (ien == '0) |-> !irq);

    assert_flush_on_disable_R12: assert property (@(posedge clk) disable iff (rst)
        !core_en |=> (cmd_lvl == '0 && rx_lvl == '0));

endmodule

bind i2cf_front i2cf_front_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .rx_valid  (rx_valid),
    .core_en   (core_en),
    .cmd_lvl   (cmd_lvl),
    .rx_lvl    (rx_lvl),
    .ist       (ist),
    .ien       (ien),
    .irq       (irq)
);

// File: tb/i2cf_front_tb.sv
module i2cf_front_tb_top;

    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cmd_valid;
    logic [9:0]  cmd_word;
    logic        cmd_ready = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        ev_nack = 1'b0, ev_arb = 1'b0, eng_busy = 1'b0;
    logic        core_en, fast_mode, irq;
    logic [15:0] scl_lo_cnt, scl_hi_cnt, sda_hold_cnt;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    i2cf_front dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_valid(cmd_valid),
        .cmd_word(cmd_word), .cmd_ready(cmd_ready), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .ev_nack(ev_nack), .ev_arb(ev_arb), .eng_busy(eng_busy),
        .core_en(core_en), .fast_mode(fast_mode), .scl_lo_cnt(scl_lo_cnt),
        .scl_hi_cnt(scl_hi_cnt), .sda_hold_cnt(sda_hold_cnt), .irq(irq)
    );

    localparam logic [5:0] A_CMD = 6'h00, A_RXD = 6'h04, A_CTRL = 6'h08, A_IEN = 6'h0C,
                           A_IST = 6'h10, A_STAT = 6'h14, A_CLVL = 6'h18, A_RLVL = 6'h1C,
                           A_SLO = 6'h20, A_SHI = 6'h24, A_HOLD = 6'h28;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic expect_reg(input logic [5:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] v;
        rd(a, v);
        check(v == exp, tag, v, exp);
    endtask

    task automatic push_rx(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic take_cmd(output logic v, output logic [9:0] w);
        @(negedge clk);
        #1 v = cmd_valid; w = cmd_word;
        cmd_ready = 1'b1;
        @(negedge clk);
        cmd_ready = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic        cv;
        logic [9:0]  cw;
        logic [9:0]  words [4];

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // ---- R1: reset state ----
        expect_reg(A_CTRL, 32'h0, "R1 ctrl");
        expect_reg(A_IEN,  32'h0, "R1 ien");
        expect_reg(A_IST,  32'h1, "R1 ist");
        expect_reg(A_STAT, 32'h0, "R1 status");
        expect_reg(A_CLVL, 32'h0, "R1 cmd level");
        expect_reg(A_RLVL, 32'h0, "R1 rx level");
        check({cmd_valid, core_en, irq} == 3'b000, "R1 outputs", {cmd_valid, core_en, irq}, 0);

        // ---- R2 / R13: register map, counts, control ----
        wr(A_SLO,  32'hABCD_1234);
        wr(A_SHI,  32'h0000_0567);
        wr(A_HOLD, 32'hFFFF_0009);
        expect_reg(A_SLO,  32'h1234, "R2 scl low");
        expect_reg(A_SHI,  32'h0567, "R2 scl high");
        expect_reg(A_HOLD, 32'h0009, "R2 sda hold");
        check(scl_lo_cnt == 16'h1234 && scl_hi_cnt == 16'h0567 && sda_hold_cnt == 16'h0009,
              "R2 count ports", {scl_lo_cnt, scl_hi_cnt}, 32'h1234_0567);
        wr(A_CTRL, 32'hFFFF_FFFF);
        expect_reg(A_CTRL, 32'h3F, "R2 ctrl width");
        check(core_en && fast_mode, "R13 en/fast set", {core_en, fast_mode}, 2'b11);
        wr(A_CTRL, 32'h2);
        check(!core_en && fast_mode, "R13 fast only", {core_en, fast_mode}, 2'b01);
        wr(A_CTRL, 32'h0);

        // ---- R12: ignored while disabled ----
        wr(A_CMD, 32'h2A5);
        push_rx(8'h77);
        @(negedge clk); ev_nack = 1'b1; @(negedge clk); ev_nack = 1'b0;
        expect_reg(A_CLVL, 32'h0, "R12 cmd ignored disabled");
        expect_reg(A_RLVL, 32'h0, "R12 rx ignored disabled");
        expect_reg(A_IST,  32'h1, "R12 event ignored disabled");

        // ---- R3 / R4 / R11: command queue ----
        wr(A_CTRL, 32'h1);
        expect_reg(A_STAT, 32'h0, "R11 idle");
        words[0] = 10'h2A4; words[1] = 10'h055; words[2] = 10'h1FF; words[3] = 10'h380;
        for (int i = 0; i < 4; i++) wr(A_CMD, {22'h3FFFFF, words[i]});
        expect_reg(A_CLVL, 32'd4, "R3 cmd level 4");
        expect_reg(A_STAT, 32'h1, "R11 busy with queued cmd");
        wr(A_CMD, 32'h0CC);
        expect_reg(A_CLVL, 32'd4, "R4 full write ignored");
        for (int i = 0; i < 4; i++) begin
            take_cmd(cv, cw);
            check(cv && cw == words[i], "R3 cmd order", {cv, cw}, {1'b1, words[i]});
        end
        check(!cmd_valid, "R4 no extra word", cmd_valid, 0);
        expect_reg(A_STAT, 32'h0, "R11 idle after drain");
        eng_busy = 1'b1;
        expect_reg(A_STAT, 32'h1, "R11 engine busy");
        wr(A_CTRL, 32'h0);
        expect_reg(A_STAT, 32'h0, "R11 disabled not busy");
        eng_busy = 1'b0;

        // ---- R8 / R5 / R6 / R7: threshold sweep ----
        for (int t = 0; t < 4; t++) begin
            wr(A_CTRL, 32'h0);
            wr(A_CTRL, 32'h1 | (t << 2) | (t << 4));
            wr(A_IST, 32'h1F);
            for (int l = 0; l <= DEPTH; l++) begin
                rd(A_IST, v);
                check(v[0] == (l <= t), "R8 tx ready", v[0], (l <= t));
                check(v[1] == 1'b0, "R8 rx ready empty", v[1], 0);
                if (l < DEPTH) wr(A_CMD, l);
            end
            wr(A_IST, 32'h3);
            rd(A_IST, v);
            check(v[0] == (DEPTH <= t), "R8 w1c no effect on live bit", v[0], (DEPTH <= t));
            for (int l = 0; l <= DEPTH; l++) begin
                rd(A_IST, v);
                check(v[1] == (l > t), "R8 rx ready", v[1], (l > t));
                push_rx(8'(t * 16 + l));
            end
            rd(A_IST, v);
            check(v[4] == 1'b1, "R7 overflow flag", v[4], 1);
            expect_reg(A_RLVL, DEPTH, "R7 level stays full");
            for (int l = 0; l < DEPTH; l++)
                expect_reg(A_RXD, 32'(t * 16 + l), "R5 rx order");
            expect_reg(A_RXD, 32'h0, "R6 empty read zero");
            expect_reg(A_RLVL, 32'h0, "R6 level zero");
            wr(A_IST, 32'h10);
            rd(A_IST, v);
            check(v[4] == 1'b0, "R9 overflow cleared", v[4], 0);
        end

        // ---- R9 / R10: events and mask ----
        wr(A_CTRL, 32'h0);
        wr(A_CTRL, 32'h1);
        wr(A_CMD, 32'h100);   // level 1 > threshold 0: TX ready low
        wr(A_IEN, 32'h04);
        check(!irq, "R10 irq idle", irq, 0);
        @(negedge clk); ev_nack = 1'b1; @(negedge clk); ev_nack = 1'b0;
        #1 check(irq, "R10 nack irq", irq, 1);
        expect_reg(A_IST, 32'h04, "R9 nack sticky");
        wr(A_IST, 32'h04);
        #1 check(!irq, "R10 irq after clear", irq, 0);
        @(negedge clk); ev_arb = 1'b1; @(negedge clk); ev_arb = 1'b0;
        expect_reg(A_IST, 32'h08, "R9 arb sticky");
        check(!irq, "R10 arb masked", irq, 0);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = A_IST; reg_wdata = 32'h08; ev_arb = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; ev_arb = 1'b0;
        expect_reg(A_IST, 32'h08, "R9 set wins over clear");
        wr(A_IST, 32'h08);
        expect_reg(A_IST, 32'h00, "R9 arb cleared");
        take_cmd(cv, cw);
        wr(A_IEN, 32'h01);
        #1 check(irq, "R10 tx ready irq", irq, 1);
        wr(A_IEN, 32'h00);

        // ---- R12: disable flushes, re-enable empty ----
        wr(A_CMD, 32'h011);
        wr(A_CMD, 32'h022);
        push_rx(8'h5A);
        push_rx(8'hA5);
        expect_reg(A_CLVL, 32'd2, "R3 level two");
        expect_reg(A_RLVL, 32'd2, "R5 level two");
        wr(A_CTRL, 32'h0);
        wr(A_CTRL, 32'h1);
        expect_reg(A_CLVL, 32'd0, "R12 cmd flushed");
        expect_reg(A_RLVL, 32'd0, "R12 rx flushed");
        check(!cmd_valid, "R12 no cmd after restart", cmd_valid, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule